// File: doc/BRIEF.md
# Indexed-Register Fine-Grained Bank Mapper

This block turns processor and picture-bus addresses into physical ROM offsets for a cartridge with many small banks. The processor's program area from 0x8000 to 0xFFFF is cut into four 8 KB windows. The 8 KB pattern area on the picture bus is cut into eight 1 KB windows. Six pattern bank numbers and two program bank numbers sit in eight bank registers. Software never writes a bank register by address. It first writes a select byte that picks a register and sets two layout bits, then it writes the bank number through a companion data address.

The program layout bit swaps the first and third program windows. The last window always holds the last bank. The pattern layout bit swaps the two 4 KB pattern halves. The first two registers each feed an aligned pair of 1 KB windows. The block also holds a mirroring bit and marks accesses to the 8 KB work-RAM window at 0x6000. All mapping is combinational from the register state, so a write takes effect on the access that follows it.

Top module: `bank_mapper_top`

## Requirements
- R1: A write to an even address in 0x8000–0x9FFF loads the register index from data bits 2:0, the program layout bit from data bit 6 and the pattern layout bit from data bit 7.
- R2: A write to an odd address in 0x8000–0x9FFF stores the whole data byte into the bank register chosen by the current index (registers numbered 0–7).
- R3: With program layout 0, the windows selected by address bits 14:13 = 0,1,2,3 map register 6, register 7, bank N-2 and bank N-1. Window 3 maps bank N-1 in every state.
- R4: With program layout 1, windows 0,1,2,3 map bank N-2, register 7, register 6 and bank N-1.
- R5: With pattern layout 0, the 1 KB windows selected by picture address bits 12:10 = 0..7 map register 0 with bit 0 cleared, register 0 with bit 0 set, register 1 with bit 0 cleared, register 1 with bit 0 set, then registers 2, 3, 4 and 5.
- R6: With pattern layout 1, windows 0..3 map registers 2..5, and windows 4..7 map the paired register 0 and register 1 banks in the order given in R5.
- R7: A write to an even address in 0xA000–0xBFFF sets the mirroring output from data bit 0 (0 = vertical, 1 = horizontal). Writes to odd addresses there, and writes outside 0x8000–0xBFFF, leave the mirroring and all mapping unchanged.
- R8: Every program bank number is reduced modulo PRG_BANKS, and every pattern bank number is reduced modulo CHR_BANKS. Offsets are bank times window size plus the in-window address.
- R9: After a synchronous reset, all registers, the index, both layout bits and the mirroring bit are zero. Until the first write to 0x8000–0x9FFF, the program windows map banks 0, 1, N-2 and N-1, and every pattern window maps bank 0.
- R10: ram_sel is high exactly for 0x6000–0x7FFF, with ram_off = address − 0x6000. prg_sel is high exactly for 0x8000–0xFFFF. The two are never high together.
- R11: A register write is visible on the outputs in the first cycle after the clock edge that accepts it, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | Processor write strobe, one write per cycle |
| cpu_addr | input | 16 | Processor address, used for both decoding and translation |
| cpu_wdata | input | 8 | Processor write data |
| ppu_addr | input | 13 | Picture-bus pattern address |
| prg_sel | output | 1 | Address lies in program ROM space |
| prg_off | output | $clog2(PRG_BANKS)+13 | Physical program ROM offset |
| ram_sel | output | 1 | Address lies in work RAM space |
| ram_off | output | 13 | Work RAM offset |
| chr_off | output | $clog2(CHR_BANKS)+10 | Physical pattern ROM offset |
| mirror_horiz | output | 1 | Mirroring: 0 vertical, 1 horizontal |

## Verification
The checker assumes that PRG_BANKS is at least 2 and that rst_n is held low for at least one clock edge before any address is trusted. It also assumes that cpu_we carries at most one write per cycle and that the write's address and data stay stable across the accepting edge. The bench keeps to these assumptions by driving all inputs on the falling edge, holding reset for several cycles and issuing single writes. It uses non-power-of-two bank counts, so the modulo checks are not trivially satisfied by truncation.

// File: rtl/mapper_pkg.sv
// Shared types for the bank mapper.
// Assumes: nothing beyond standard SystemVerilog packages.
package mapper_pkg;

    typedef enum logic {
        MIR_VERTICAL   = 1'b0,
        MIR_HORIZONTAL = 1'b1
    } mirror_t;

    localparam int NUM_BANK_REGS = 8;
    localparam logic [2:0] REGION_CTRL  = 3'b100;   // 0x8000-0x9FFF
    localparam logic [2:0] REGION_MIRR  = 3'b101;   // 0xA000-0xBFFF
    localparam logic [2:0] REGION_WRAM  = 3'b011;   // 0x6000-0x7FFF

endpackage

// File: rtl/mapper_regs.sv
// Register file of the mapper: eight bank registers written through an
// index, two layout bits, the mirroring bit and a flag that records the
// first write to the control region.
// Assumes: at most one write per cycle; addr_hi is cpu_addr[15:13].
module mapper_regs
    import mapper_pkg::*;
#(
    parameter int NREG = NUM_BANK_REGS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [2:0]            addr_hi,
    input  logic                  addr_lsb,
    input  logic [7:0]            wdata,
    output logic [NREG-1:0][7:0]  bank_q,
    output logic                  prg_layout,
    output logic                  chr_layout,
    output mirror_t               mirror,
    output logic                  synced
);
    localparam int IDX_W = $clog2(NREG);

    logic [IDX_W-1:0] idx_q;
    logic             ctrl_wr;
    logic             sel_wr;
    logic             data_wr;
    logic             mir_wr;

    // Decode which register group the current write targets.
    always_comb begin
        ctrl_wr = we && (addr_hi == REGION_CTRL);
        sel_wr  = ctrl_wr && !addr_lsb;
        data_wr = ctrl_wr &&  addr_lsb;
        mir_wr  = we && (addr_hi == REGION_MIRR) && !addr_lsb;
    end

    // Select byte: index and both layout bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            prg_layout <= 1'b0;
            chr_layout <= 1'b0;
        end else if (sel_wr) begin
            idx_q      <= wdata[IDX_W-1:0];
            prg_layout <= wdata[6];
            chr_layout <= wdata[7];
        end
    end

    // One bank register per index value.
    for (genvar g = 0; g < NREG; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[g] <= 8'h00;
            else if (data_wr && (idx_q == IDX_W'(g)))
                bank_q[g] <= wdata;
        end
    end

    // Mirroring bit from even writes in the mirroring region.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mirror <= MIR_VERTICAL;
        else if (mir_wr)
            mirror <= mirror_t'(wdata[0]);
    end

    // Records that the control region has been written since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            synced <= 1'b0;
        else if (ctrl_wr)
            synced <= 1'b1;
    end

endmodule

// File: rtl/mapper_prg_map.sv
// Program window translation: picks the 8 KB bank for one of four windows.
// Assumes: PRG_BANKS >= 2 and PRG_BANKS <= 256.
module mapper_prg_map #(
    parameter int PRG_BANKS = 24
) (
    input  logic [7:0]                     reg6,
    input  logic [7:0]                     reg7,
    input  logic                           prg_layout,
    input  logic                           synced,
    input  logic [1:0]                     win,
    output logic [$clog2(PRG_BANKS)-1:0]   bank
);
    localparam int         PB_W        = $clog2(PRG_BANKS);
    localparam logic [7:0] SECOND_LAST = 8'(PRG_BANKS - 2);
    localparam logic [7:0] LAST        = 8'(PRG_BANKS - 1);

    logic [7:0] raw;

    // Choose the raw bank number for the window, then fold it into range.
    always_comb begin
        unique case (win)
            2'd0:    raw = !synced ? 8'd0 : (prg_layout ? SECOND_LAST : reg6);
            2'd1:    raw = !synced ? 8'd1 : reg7;
            2'd2:    raw = prg_layout ? reg6 : SECOND_LAST;
            default: raw = LAST;
        endcase
        bank = PB_W'(32'(raw) % PRG_BANKS);
    end

endmodule

// File: rtl/mapper_chr_map.sv
// Pattern window translation: picks the 1 KB bank for one of eight windows.
// Assumes: CHR_BANKS <= 256; regs_i holds bank registers 0..5.
module mapper_chr_map #(
    parameter int CHR_BANKS = 96
) (
    input  logic [5:0][7:0]                regs_i,
    input  logic                           chr_layout,
    input  logic                           synced,
    input  logic [2:0]                     win,
    output logic [$clog2(CHR_BANKS)-1:0]   bank
);
    localparam int CB_W = $clog2(CHR_BANKS);

    logic [2:0] eff_win;
    logic [7:0] pair_reg;
    logic [7:0] raw;

    // Swap halves by layout bit, then pick paired or single register.
    always_comb begin
        eff_win  = win ^ {chr_layout, 2'b00};
        pair_reg = eff_win[1] ? regs_i[1] : regs_i[0];
        if (!synced)
            raw = 8'd0;
        else if (!eff_win[2])
            raw = {pair_reg[7:1], eff_win[0]};
        else
            raw = regs_i[{1'b0, eff_win[1:0]} + 3'd2];
        bank = CB_W'(32'(raw) % CHR_BANKS);
    end

endmodule

// File: rtl/bank_mapper_top.sv
// Top of the indexed-register bank mapper: decodes writes, holds bank
// state and translates both bus addresses into physical offsets.
// Assumes: PRG_BANKS >= 2; both counts at most 256.
module bank_mapper_top
    import mapper_pkg::*;
#(
    parameter int PRG_BANKS = 24,
    parameter int CHR_BANKS = 96,
    localparam int PRG_OFF_W = $clog2(PRG_BANKS) + 13,
    localparam int CHR_OFF_W = $clog2(CHR_BANKS) + 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_we,
    input  logic [15:0]          cpu_addr,
    input  logic [7:0]           cpu_wdata,
    input  logic [12:0]          ppu_addr,
    output logic                 prg_sel,
    output logic [PRG_OFF_W-1:0] prg_off,
    output logic                 ram_sel,
    output logic [12:0]          ram_off,
    output logic [CHR_OFF_W-1:0] chr_off,
    output logic                 mirror_horiz
);
    localparam int PB_W = $clog2(PRG_BANKS);
    localparam int CB_W = $clog2(CHR_BANKS);

    logic [NUM_BANK_REGS-1:0][7:0] bank_q;
    logic                          prg_layout;
    logic                          chr_layout;
    logic                          synced;
    mirror_t                       mirror;
    logic [PB_W-1:0]               prg_bank;
    logic [CB_W-1:0]               chr_bank;

    mapper_regs #(.NREG(NUM_BANK_REGS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cpu_we),
        .addr_hi    (cpu_addr[15:13]),
        .addr_lsb   (cpu_addr[0]),
        .wdata      (cpu_wdata),
        .bank_q     (bank_q),
        .prg_layout (prg_layout),
        .chr_layout (chr_layout),
        .mirror     (mirror),
        .synced     (synced)
    );

    mapper_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .reg6       (bank_q[6]),
        .reg7       (bank_q[7]),
        .prg_layout (prg_layout),
        .synced     (synced),
        .win        (cpu_addr[14:13]),
        .bank       (prg_bank)
    );

    mapper_chr_map #(.CHR_BANKS(CHR_BANKS)) u_chr (
        .regs_i     (bank_q[5:0]),
        .chr_layout (chr_layout),
        .synced     (synced),
        .win        (ppu_addr[12:10]),
        .bank       (chr_bank)
    );

    // Region decode and offset assembly.
    always_comb begin
        prg_sel      = cpu_addr[15];
        ram_sel      = (cpu_addr[15:13] == REGION_WRAM);
        ram_off      = cpu_addr[12:0];
        prg_off      = {prg_bank, cpu_addr[12:0]};
        chr_off      = {chr_bank, ppu_addr[9:0]};
        mirror_horiz = (mirror == MIR_HORIZONTAL);
    end

endmodule

// File: rtl/mapper_chk.sv
// Property checker for the bank mapper, bound to the top module.
// Assumes: reset held for at least one edge; single writes per cycle.
module mapper_chk #(
    parameter int PRG_BANKS = 24,
    parameter int CHR_BANKS = 96
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cpu_we,
    input logic [15:0]                   cpu_addr,
    input logic                          wdata_b0,
    input logic                          prg_sel,
    input logic                          ram_sel,
    input logic [$clog2(PRG_BANKS)-1:0]  prg_bank,
    input logic [$clog2(CHR_BANKS)-1:0]  chr_bank,
    input logic                          mirror_horiz
);
    logic mir_write;
    assign mir_write = cpu_we && (cpu_addr[15:13] == 3'b101) && !cpu_addr[0];

    // R3: the top program window always holds the last bank.
    p_last_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> (32'(prg_bank) == PRG_BANKS - 1));

    // R7: mirroring moves only on an even mirroring-region write.
    p_mirror_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mir_write |=> $stable(mirror_horiz));

    // R7: mirroring follows data bit 0 of the accepted write.
    p_mirror_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mir_write |=> (mirror_horiz == $past(wdata_b0)));

    // R8: program bank stays below the bank count.
    p_prg_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        32'(prg_bank) < PRG_BANKS);

    // R8: pattern bank stays below the bank count.
    p_chr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        32'(chr_bank) < CHR_BANKS);

    // R10: RAM and ROM selects never overlap.
    p_sel_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prg_sel, ram_sel}));

endmodule

bind bank_mapper_top mapper_chk #(
    .PRG_BANKS(PRG_BANKS),
    .CHR_BANKS(CHR_BANKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .wdata_b0     (cpu_wdata[0]),
    .prg_sel      (prg_sel),
    .ram_sel      (ram_sel),
    .prg_bank     (prg_off[PRG_OFF_W-1:13]),
    .chr_bank     (chr_off[CHR_OFF_W-1:10]),
    .mirror_horiz (mirror_horiz)
);

// File: tb/tb_bank_mapper_top.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module tb_bank_mapper_top;
    localparam int NPRG = 24;
    localparam int NCHR = 96;
    localparam int POW  = $clog2(NPRG) + 13;
    localparam int COW  = $clog2(NCHR) + 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cpu_we = 1'b0;
    logic [15:0]     cpu_addr = 16'h0;
    logic [7:0]      cpu_wdata = 8'h0;
    logic [12:0]     ppu_addr = 13'h0;
    logic            prg_sel;
    logic [POW-1:0]  prg_off;
    logic            ram_sel;
    logic [12:0]     ram_off;
    logic [COW-1:0]  chr_off;
    logic            mirror_horiz;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_reg [8];
    int m_idx, m_pm, m_inv, m_mir, m_sync;

    bank_mapper_top #(.PRG_BANKS(NPRG), .CHR_BANKS(NCHR)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .prg_sel(prg_sel),
        .prg_off(prg_off), .ram_sel(ram_sel), .ram_off(ram_off),
        .chr_off(chr_off), .mirror_horiz(mirror_horiz)
    );

    always #10 clk = ~clk;

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_reg[i] = 0;
        m_idx = 0; m_pm = 0; m_inv = 0; m_mir = 0; m_sync = 0;
    endtask

    function automatic int exp_prg_bank(int w);
        int v;
        if (!m_sync) begin
            case (w) 0: v = 0; 1: v = 1; 2: v = NPRG - 2; default: v = NPRG - 1; endcase
        end else if (m_pm == 0) begin
            case (w) 0: v = m_reg[6]; 1: v = m_reg[7]; 2: v = NPRG - 2; default: v = NPRG - 1; endcase
        end else begin
            case (w) 0: v = NPRG - 2; 1: v = m_reg[7]; 2: v = m_reg[6]; default: v = NPRG - 1; endcase
        end
        return v % NPRG;
    endfunction

    function automatic int exp_chr_bank(int w);
        int lst [8];
        lst[0] = m_reg[0] & 8'hFE; lst[1] = m_reg[0] | 1;
        lst[2] = m_reg[1] & 8'hFE; lst[3] = m_reg[1] | 1;
        lst[4] = m_reg[2]; lst[5] = m_reg[3]; lst[6] = m_reg[4]; lst[7] = m_reg[5];
        if (!m_sync) return 0;
        if (m_inv) return lst[(w + 4) % 8] % NCHR;
        return lst[w] % NCHR;
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        int a = int'(cpu_addr);
        int p = int'(ppu_addr);
        cmp(tag, "prg_sel", int'(prg_sel), (a >= 32'h8000) ? 1 : 0);
        cmp(tag, "ram_sel", int'(ram_sel), (a >= 32'h6000 && a < 32'h8000) ? 1 : 0);
        if (a >= 32'h6000 && a < 32'h8000)
            cmp(tag, "ram_off", int'(ram_off), a - 32'h6000);
        cmp(tag, "prg_off", int'(prg_off), exp_prg_bank((a / 8192) % 4) * 8192 + (a % 8192));
        cmp(tag, "chr_off", int'(chr_off), exp_chr_bank(p / 1024) * 1024 + (p % 1024));
        cmp(tag, "mirror", int'(mirror_horiz), m_mir);
    endtask

    // One bus cycle: drive on the falling edge, compare, then advance the model.
    task automatic step(bit we, int a, int d, int p, string tag);
        @(negedge clk);
        cpu_we = we; cpu_addr = 16'(a); cpu_wdata = 8'(d); ppu_addr = 13'(p);
        #5;
        if (rst_n) check_all(tag);
        @(posedge clk);
        if (!rst_n) model_reset();
        else if (we) begin
            if ((a / 8192) == 4) begin
                m_sync = 1;
                if (a % 2 == 0) begin
                    m_idx = d & 7; m_pm = (d >> 6) & 1; m_inv = (d >> 7) & 1;
                end else m_reg[m_idx] = d & 255;
            end else if ((a / 8192) == 5 && a % 2 == 0) m_mir = d & 1;
        end
    endtask

    task automatic sweep(string tag);
        for (int w = 0; w < 8; w++)
            step(1'b0, 32'h8000 + (w % 4) * 8192 + 32'h0123 + w, 0, w * 1024 + 32'h2A5 - w, tag);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) step(1'b0, 0, 0, 0, "R9");
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int vals [8];
        vals = '{8'h0B, 8'h64, 8'h05, 8'h7F, 8'h12, 8'hFF, 8'h25, 8'h03};
        model_reset();
        do_reset();
        // R9: reset layout before any control write
        sweep("R9");
        // R10: region decode
        step(1'b0, 32'h6000, 0, 0, "R10");
        step(1'b0, 32'h7FFF, 0, 0, "R10");
        step(1'b0, 32'h5FFF, 0, 0, "R10");
        step(1'b0, 32'h4000, 0, 0, "R10");
        step(1'b1, 32'h6002, 8'h81, 0, "R10");
        sweep("R10");
        // R1 R2: program all eight registers through select/data
        for (int i = 0; i < 8; i++) begin
            step(1'b1, (i % 2) ? 32'h9FFE : 32'h8000, i, 0, "R1");
            step(1'b1, (i % 2) ? 32'h9FFF : 32'h8001, vals[i], 0, "R2");
        end
        sweep("R3");
        sweep("R5");
        sweep("R8");
        // R4: program layout 1
        step(1'b1, 32'h8000, 8'h46, 0, "R1");
        sweep("R4");
        // R6: pattern layout swapped
        step(1'b1, 32'h8000, 8'h80, 0, "R1");
        sweep("R6");
        step(1'b1, 32'h8000, 8'hC7, 0, "R1");
        sweep("R1");
        // R11: write R7 then observe window 1 before and after the edge
        step(1'b1, 32'h8001, 8'h11, 0, "R11");
        step(1'b0, 32'hA123, 0, 0, "R11");
        // R7: mirroring
        step(1'b1, 32'hA000, 8'h01, 0, "R7");
        step(1'b1, 32'hA001, 8'h00, 0, "R7");
        step(1'b1, 32'hC000, 8'h00, 0, "R7");
        step(1'b1, 32'hE001, 8'h00, 0, "R7");
        sweep("R7");
        step(1'b1, 32'hBFFE, 8'hFE, 0, "R7");
        step(1'b0, 32'h8000, 0, 0, "R7");
        // R2: data write reaches register 3 only
        step(1'b1, 32'h8000, 8'h03, 0, "R2");
        step(1'b1, 32'h8001, 8'h5A, 0, "R2");
        sweep("R2");
        // R9: second reset restores defaults
        do_reset();
        sweep("R9");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule